// File: doc/BRIEF.md
# High/Low Count Programmable Clock Divider

This block derives a slower clock from its input clock. The output waveform is not set by a single terminal count. It is set by two separate counts. The high count is the number of input cycles the output stays high, and the low count is the number of input cycles it stays low. An odd-ratio flag stretches the high phase by half an input cycle, using the falling edge of the input clock, so that odd ratios come out close to 50% duty. A bypass flag passes the input clock straight through, which gives divide-by-one.

Software or a neighbouring controller loads the configuration through a small write port. Four word formats are accepted:
- a timing word that carries both counts;
- a control word that carries the two flags;
- a ratio word, holding a plain integer ratio that an internal encoder turns into all four fields;
- a single-word form that packs the counts and both flags together.

A write goes into a staging register. The running configuration takes the staged value only at the end of the current output period, so the output never shows a shortened pulse. The ready output reports whether a staged configuration is still waiting to take effect.

Top module: `hilo_clk_div`

## Requirements
- R1: Select 0 (timing word) loads the low count from data bits 5:0 and the high count from bits 11:6. The flags are unchanged. With the odd flag clear, the output is high for `high` input cycles and then low for `low` input cycles.
- R2: Select 1 (control word) loads the odd flag from data bit 7 and the bypass flag from bit 6. With the odd flag set and bypass clear:
  - the high phase lasts 2*high+1 input half-cycles;
  - the low phase lasts 2*low-1 input half-cycles.
- R3: Select 2 (ratio word) takes a ratio N from data bits 7:0 and sets the fields as follows:
  - high = N/2, rounded down;
  - low = N - high;
  - odd flag = N mod 2;
  - bypass = 1 only when N equals 1.
  The output period is therefore N input cycles, with the high phase N half-cycles long.
- R4: While the bypass flag is active, the output clock equals the input clock, whatever the count fields hold.
- R5: A count field of zero means 64. The ratio word with N = 128 therefore gives 64 cycles high and 64 cycles low. A timing word of all zeros gives the same result.
- R6: Select 3 (single-word form) loads:
  - low from bits 5:0;
  - high from bits 11:6;
  - bypass from bit 12;
  - odd flag from bit 13.
- R7: A written configuration takes effect only when the current output period ends. Ready goes low in the cycle after a write and stays low until that period boundary. When no write is pending it stays high.
- R8: Reset behaves as follows:
  - the running configuration becomes the one encoded from parameter DEF_RATIO (default 4);
  - ready reads high;
  - the output is held low;
  - the first period after reset starts with the high phase.
- R9: A timing-word write leaves the odd and bypass flags as they were before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_sel | input | 2 | Word format: 0 timing, 1 control, 2 ratio, 3 single-word |
| cfg_data | input | 16 | Configuration data |
| clk_out | output | 1 | Divided clock |
| cfg_ready | output | 1 | High when no staged configuration is waiting |

## Verification
The hardest situation to reach is a write that lands in the middle of a long period. To check it, the stimulus first runs the 128-cycle ratio. It then locks onto a rising output edge, waits some twenty half-cycles into the high phase and only then writes a short ratio. The bench confirms two things: no new rising edge appears before ready returns, and the gap until ready returns matches the remaining part of the old period.

To observe the half-cycle stretch, the output is sampled twice per input cycle, once between each pair of edges. Every high and low phase is then counted in half-cycles.

// File: rtl/hlcd_pkg.sv
`timescale 1ns/1ps
package hlcd_pkg;

   // Width of one count field; a zero field stands for 2**CNT_FLD_W.
   localparam int unsigned CNT_FLD_W = 6;
   // A full period (two fields) needs two more bits than one field.
   localparam int unsigned PER_W     = CNT_FLD_W + 2;
   localparam int unsigned RAT_W     = CNT_FLD_W + 2;

   typedef enum logic [1:0] {
      SEL_TIMING = 2'd0,
      SEL_CTRL   = 2'd1,
      SEL_RATIO  = 2'd2,
      SEL_INDIV  = 2'd3
   } cfg_sel_e;

   typedef struct packed {
      logic                 bypass_f;
      logic                 odd_f;
      logic [CNT_FLD_W-1:0] hi_f;
      logic [CNT_FLD_W-1:0] lo_f;
   } div_cfg_t;

   // Integer ratio to count fields.
   function automatic div_cfg_t ratio_to_cfg(input logic [RAT_W-1:0] n);
      div_cfg_t   c;
      logic [RAT_W-1:0] h;
      logic [RAT_W-1:0] l;
      h          = n >> 1;
      l          = n - h;
      c.hi_f     = h[CNT_FLD_W-1:0];
      c.lo_f     = l[CNT_FLD_W-1:0];
      c.odd_f    = n[0];
      c.bypass_f = (n == RAT_W'(1));
      return c;
   endfunction

   // Field to cycle count, zero meaning the full field range.
   function automatic logic [PER_W-1:0] field_cycles(input logic [CNT_FLD_W-1:0] f);
      logic [PER_W-1:0] r;
      if (f == '0) r = PER_W'(1) << CNT_FLD_W;
      else         r = PER_W'(f);
      return r;
   endfunction

endpackage

// File: rtl/hlcd_ratio_enc.sv
`timescale 1ns/1ps
module hlcd_ratio_enc
   import hlcd_pkg::*;
#(
   parameter int unsigned RATIO_W = 8
) (
   input  logic [RATIO_W-1:0] ratio,
   output div_cfg_t           cfg
);

   localparam int unsigned PAD_W = (RATIO_W < RAT_W) ? (RAT_W - RATIO_W) : 0;

   logic [RAT_W-1:0] ratio_ext;

   generate
      if (RATIO_W == RAT_W) begin : g_same
         assign ratio_ext = ratio;
      end else if (RATIO_W < RAT_W) begin : g_pad
         assign ratio_ext = {{PAD_W{1'b0}}, ratio};
      end else begin : g_cut
         assign ratio_ext = ratio[RAT_W-1:0];
      end
   endgenerate

   assign cfg = ratio_to_cfg(ratio_ext);

endmodule

// File: rtl/hlcd_cfg_stage.sv
`timescale 1ns/1ps
module hlcd_cfg_stage
   import hlcd_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned DEF_RATIO = 4
) (
   input  logic              clk_in,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_data,
   input  div_cfg_t          enc_cfg,
   input  logic              period_end,
   output div_cfg_t          act_cfg,
   output logic              cfg_ready
);

   localparam int unsigned LO_LSB      = 0;
   localparam int unsigned HI_LSB      = CNT_FLD_W;
   localparam int unsigned CTRL_BYP_B  = 6;
   localparam int unsigned CTRL_ODD_B  = 7;
   localparam int unsigned INDIV_BYP_B = 2 * CNT_FLD_W;
   localparam int unsigned INDIV_ODD_B = 2 * CNT_FLD_W + 1;
   localparam div_cfg_t    RST_CFG     = ratio_to_cfg(RAT_W'(DEF_RATIO));

   div_cfg_t stg_q;
   div_cfg_t act_q;
   logic     pend_q;
   cfg_sel_e sel;

   assign sel = cfg_sel_e'(cfg_sel);

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= RST_CFG;
      end else if (cfg_we) begin
         unique case (sel)
            SEL_TIMING: begin
               stg_q.lo_f <= cfg_data[LO_LSB +: CNT_FLD_W];
               stg_q.hi_f <= cfg_data[HI_LSB +: CNT_FLD_W];
            end
            SEL_CTRL: begin
               stg_q.odd_f    <= cfg_data[CTRL_ODD_B];
               stg_q.bypass_f <= cfg_data[CTRL_BYP_B];
            end
            SEL_RATIO: begin
               stg_q <= enc_cfg;
            end
            SEL_INDIV: begin
               stg_q.lo_f     <= cfg_data[LO_LSB +: CNT_FLD_W];
               stg_q.hi_f     <= cfg_data[HI_LSB +: CNT_FLD_W];
               stg_q.odd_f    <= cfg_data[INDIV_ODD_B];
               stg_q.bypass_f <= cfg_data[INDIV_BYP_B];
            end
            default: stg_q <= stg_q;
         endcase
      end
   end

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= RST_CFG;
         pend_q <= 1'b0;
      end else begin
         if (period_end && pend_q) act_q <= stg_q;
         if (cfg_we)               pend_q <= 1'b1;
         else if (period_end)      pend_q <= 1'b0;
      end
   end

   assign act_cfg   = act_q;
   assign cfg_ready = ~pend_q;

endmodule

// File: rtl/hlcd_wave_gen.sv
`timescale 1ns/1ps
module hlcd_wave_gen
   import hlcd_pkg::*;
#(
   parameter bit HALF_EN = 1'b1
) (
   input  logic     clk_in,
   input  logic     rst_n,
   input  div_cfg_t act_cfg,
   output logic     clk_out,
   output logic     period_end,
   output logic     phase_hi
);

   logic [PER_W-1:0] hi_cyc;
   logic [PER_W-1:0] lo_cyc;
   logic [PER_W-1:0] per_last;
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] cnt_nxt;
   logic             hi_q;
   logic             shaped;

   assign hi_cyc     = field_cycles(act_cfg.hi_f);
   assign lo_cyc     = field_cycles(act_cfg.lo_f);
   assign per_last   = hi_cyc + lo_cyc - PER_W'(1);
   assign cnt_nxt    = cnt_q + PER_W'(1);
   assign period_end = act_cfg.bypass_f || (cnt_q >= per_last);

   // Counter reset to all ones so the first edge after reset opens a period.
   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '1;
         hi_q  <= 1'b0;
      end else if (period_end) begin
         cnt_q <= '0;
         hi_q  <= 1'b1;
      end else begin
         cnt_q <= cnt_nxt;
         hi_q  <= (cnt_nxt < hi_cyc);
      end
   end

   generate
      if (HALF_EN) begin : g_half
         logic ext_q;
         always_ff @(negedge clk_in or negedge rst_n) begin
            if (!rst_n) ext_q <= 1'b0;
            else        ext_q <= hi_q;
         end
         assign shaped = hi_q | (act_cfg.odd_f & ext_q);
      end else begin : g_whole
         assign shaped = hi_q;
      end
   endgenerate

   assign clk_out  = act_cfg.bypass_f ? clk_in : shaped;
   assign phase_hi = hi_q;

endmodule

// File: rtl/hilo_clk_div.sv
`timescale 1ns/1ps
module hilo_clk_div
   import hlcd_pkg::*;
#(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned RATIO_W   = 8,
   parameter int unsigned DEF_RATIO = 4,
   parameter bit          HALF_EN   = 1'b1
) (
   input  logic              clk_in,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [DATA_W-1:0] cfg_data,
   output logic              clk_out,
   output logic              cfg_ready
);

   localparam int unsigned MIN_DATA_W = 2 * CNT_FLD_W + 2;

   generate
      if (DATA_W < MIN_DATA_W) begin : g_bad_data_w
         $error("hilo_clk_div: DATA_W too narrow for the single-word form");
      end
      if (RATIO_W != RAT_W) begin : g_bad_ratio_w
         $error("hilo_clk_div: RATIO_W must equal two more than the field width");
      end
      if (DEF_RATIO > (1 << RAT_W)) begin : g_bad_def
         $error("hilo_clk_div: DEF_RATIO out of range");
      end
   endgenerate

   div_cfg_t enc_cfg;
   div_cfg_t act_cfg;
   logic     period_end;
   logic     phase_hi;

   hlcd_ratio_enc #(
      .RATIO_W (RATIO_W)
   ) u_enc (
      .ratio (cfg_data[RATIO_W-1:0]),
      .cfg   (enc_cfg)
   );

   hlcd_cfg_stage #(
      .DATA_W    (DATA_W),
      .DEF_RATIO (DEF_RATIO)
   ) u_stage (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_sel    (cfg_sel),
      .cfg_data   (cfg_data),
      .enc_cfg    (enc_cfg),
      .period_end (period_end),
      .act_cfg    (act_cfg),
      .cfg_ready  (cfg_ready)
   );

   hlcd_wave_gen #(
      .HALF_EN (HALF_EN)
   ) u_wave (
      .clk_in     (clk_in),
      .rst_n      (rst_n),
      .act_cfg    (act_cfg),
      .clk_out    (clk_out),
      .period_end (period_end),
      .phase_hi   (phase_hi)
   );

endmodule

// File: rtl/hlcd_checker.sv
`timescale 1ns/1ps
module hlcd_checker
   import hlcd_pkg::*;
(
   input logic     clk_in,
   input logic     rst_n,
   input logic     cfg_we,
   input logic     cfg_ready,
   input logic     period_end,
   input div_cfg_t act_cfg,
   input logic     phase_hi
);

   // R7: a write always leaves a pending configuration behind
   assert_write_pends_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
      cfg_we |=> !cfg_ready);

   // R7: with nothing written, ready does not drop
   assert_ready_holds_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
      (cfg_ready && !cfg_we) |=> cfg_ready);

   // R7: a pending configuration is taken at the period boundary
   assert_commit_at_end_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
      (!cfg_ready && period_end && !cfg_we) |=> cfg_ready);

   // R7: the running configuration moves only after a period end
   assert_cfg_moves_at_end_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
      !$stable(act_cfg) |-> $past(period_end));

   // R1: every divided period opens with the high phase
   assert_period_opens_high_R1: assert property (@(posedge clk_in) disable iff (!rst_n)
      period_end |=> (act_cfg.bypass_f || phase_hi));

endmodule

bind hilo_clk_div hlcd_checker u_chk (
   .clk_in     (clk_in),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .cfg_ready  (cfg_ready),
   .period_end (period_end),
   .act_cfg    (act_cfg),
   .phase_hi   (phase_hi)
);

// File: tb/hilo_clk_div_tb_top.sv
`timescale 1ns/1ps
module hilo_clk_div_tb_top;

   logic        clk_in = 1'b0;
   logic        rst_n  = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = 2'd0;
   logic [15:0] cfg_data = 16'd0;
   logic        clk_out;
   logic        cfg_ready;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   always #10 clk_in = ~clk_in;

   hilo_clk_div dut_i (
      .clk_in    (clk_in),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_data  (cfg_data),
      .clk_out   (clk_out),
      .cfg_ready (cfg_ready)
   );

   // {requirement, select, data, expected high half-cycles, expected low half-cycles}
   localparam int NVEC = 17;
   localparam int VEC [NVEC][5] = '{
      '{3, 2, 2,      2,   2},
      '{3, 2, 3,      3,   3},
      '{3, 2, 7,      7,   7},
      '{3, 2, 10,     10,  10},
      '{1, 0, 323,    10,  6},
      '{2, 1, 128,    11,  5},
      '{9, 0, 66,     3,   3},
      '{6, 3, 132,    4,   8},
      '{6, 3, 8387,   7,   5},
      '{4, 2, 1,      1,   1},
      '{6, 3, 4161,   1,   1},
      '{5, 2, 128,    128, 128},
      '{5, 0, 0,      128, 128},
      '{3, 2, 5,      5,   5},
      '{5, 2, 127,    127, 127},
      '{4, 1, 64,     1,   1},
      '{2, 1, 0,      126, 128}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One sample between every pair of input clock edges.
   task automatic next_slot(output logic v);
      @(clk_in);
      #5;
      v = clk_out;
   endtask

   task automatic cfg_write(input int sel, input int data);
      @(negedge clk_in);
      cfg_we   = 1'b1;
      cfg_sel  = sel[1:0];
      cfg_data = data[15:0];
      @(negedge clk_in);
      cfg_we   = 1'b0;
   endtask

   task automatic measure(output int hi_n, output int lo_n);
      logic v;
      logic p;
      int   guard;
      guard = 0;
      next_slot(v);
      while (!cfg_ready && guard < 2000) begin
         next_slot(v);
         guard++;
      end
      guard = 0;
      p = v;
      next_slot(v);
      while (!(p == 1'b0 && v == 1'b1) && guard < 1000) begin
         p = v;
         next_slot(v);
         guard++;
      end
      hi_n = 0;
      while (v == 1'b1 && hi_n < 1000) begin
         hi_n++;
         next_slot(v);
      end
      lo_n = 0;
      while (v == 1'b0 && lo_n < 1000) begin
         lo_n++;
         next_slot(v);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk_in);
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int hi_n;
      int lo_n;
      logic v;
      logic p;
      int   slots;
      int   rises;

      // R8: reset state
      repeat (4) @(negedge clk_in);
      #5;
      chk("R8 output low in reset", int'(clk_out), 0);
      chk("R8 ready high in reset", int'(cfg_ready), 1);
      rst_n = 1'b1;
      @(posedge clk_in);
      #5;
      chk("R8 first period opens high", int'(clk_out), 1);
      measure(hi_n, lo_n);
      chk("R8 default high half-cycles", hi_n, 4);
      chk("R8 default low half-cycles", lo_n, 4);

      // Table walk: R1 R2 R3 R4 R5 R6 R9
      for (int i = 0; i < NVEC; i++) begin
         cfg_write(VEC[i][1], VEC[i][2]);
         measure(hi_n, lo_n);
         chk($sformatf("R%0d vector %0d high", VEC[i][0], i), hi_n, VEC[i][3]);
         chk($sformatf("R%0d vector %0d low", VEC[i][0], i), lo_n, VEC[i][4]);
      end

      // R7: write in the middle of a long period
      cfg_write(2, 128);
      measure(hi_n, lo_n);
      p = 1'b1;
      v = 1'b1;
      for (int k = 0; k < 20; k++) next_slot(v);
      cfg_write(2, 2);
      #5;
      chk("R7 ready low after write", int'(cfg_ready), 0);
      slots = 0;
      rises = 0;
      p = clk_out;
      while (!cfg_ready && slots < 1000) begin
         next_slot(v);
         if (p == 1'b0 && v == 1'b1 && !cfg_ready) rises++;
         p = v;
         slots++;
      end
      chk("R7 no new period before commit", rises, 0);
      chk("R7 commit waits for period end", int'(slots >= 200 && slots <= 256), 1);
      measure(hi_n, lo_n);
      chk("R7 new ratio after commit high", hi_n, 2);
      chk("R7 new ratio after commit low", lo_n, 2);

      // R7: ready remains high when idle
      for (int k = 0; k < 10; k++) next_slot(v);
      chk("R7 ready stays high when idle", int'(cfg_ready), 1);

      finish_run();
   end

endmodule